// File: doc/BRIEF.md
# SWD Core Halt Sequencer

This controller sits above a single-transfer SWD engine. It takes a Cortex-M target from an unknown line state to a halted core that is ready for word-sized memory access through the memory access port. It hands the engine abstract requests and waits for each reply. A request is a line reset, a 16-bit bit pattern, or a DP/AP register transfer. A reply carries a 3-bit acknowledge code and 32 bits of read data. The controller never drives the wire itself.

A `start` pulse runs the whole script. The script resets the line, switches the port to SWD, reads and optionally checks the ID register, and powers up the debug domain. It then probes the access port's identity, sets the transfer size, and writes the halt request to the debug halting control/status register. It polls that register until the core reports halted. When the run ends, `done` or `err` stays high. `err` comes with a cause code and the script step that failed. From `done`, a `rehalt` pulse repeats only the halt write and the halt poll, with no line reset.

Top module: `swd_halt_seq`

## Requirements
- R1: After reset, `done`, `err`, `busy` and `req_valid` are low, `idcode` is zero, and `err_cause` is 0.
- R2: `start` issues these requests in order: step 0 line reset (`req_op`=1), step 1 bit pattern (`req_op`=2) with `req_wdata[15:0]`=0xE79E, step 2 line reset, step 3 DP read at `req_addr`=0. The step 3 data appears on `idcode`.
- R3: Step 4 is a DP write to address 1 of 0x50000000. Step 5 is a DP read of address 1, repeated until bits 31 and 29 are both set. After 32 reads without both bits set, the run ends with `err_cause`=3 and `err_step`=5.
- R4: Access port setup is, in order: step 6 DP write address 2 = 0x000000F0; step 7 AP read address 3; step 8 DP read address 3; step 9 DP write address 2 = 0; step 10 AP write address 0 = 0x23000002.
- R5: The halt is step 11, an AP write to address 1 of 0xE000EDF0, then step 12, an AP write to address 3 of 0xA05F0003. After that, step 13 (AP read address 3) and step 14 (DP read address 3) repeat until the step 14 data has bits 17:16 both set, which raises `done`. After 64 polls that do not show the halt, the run ends with `err_cause`=3 and `err_step`=14.
- R6: An acknowledge of WAIT (3'b010) reissues the same request, up to 16 times. A 17th consecutive WAIT ends the run with `err_cause`=2 and that step's number in `err_step`.
- R7: An acknowledge of FAULT (3'b100), or any code other than OK (3'b001) or WAIT, ends the run with `err_cause`=1 and the current step number in `err_step`. The acknowledge code is ignored for line resets and bit patterns.
- R8: When `id_check_en` is high and the ID read differs from `id_expect` in any bit set in `id_mask`, the run ends with `err_cause`=4 and `err_step`=3. Differences outside the mask are ignored.
- R9: `rehalt` while `done` is high starts at step 11 and issues no line reset. `rehalt` is ignored unless `done` is high.
- R10: Once `req_valid` is high it stays high, with every request field unchanged, until `req_ready` is seen. Only one request is outstanding at a time.
- R11: `start` is ignored while `busy` is high. From `done` or `err`, `start` runs the full script again from step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run the full connect-and-halt script |
| rehalt | input | 1 | Repeat the halt write and poll (only from done) |
| id_check_en | input | 1 | Enable the ID comparison |
| id_expect | input | 32 | Expected ID value |
| id_mask | input | 32 | Bits of the ID that are compared |
| req_valid | output | 1 | Request to the engine is pending |
| req_ready | input | 1 | Engine accepts the request |
| req_op | output | 2 | 0 transfer, 1 line reset, 2 16-bit pattern |
| req_ap | output | 1 | 1 = access port, 0 = debug port |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_addr | output | 2 | Register address bits 3:2 |
| req_wdata | output | 32 | Write data or pattern |
| rsp_valid | input | 1 | Engine reply is present |
| rsp_ack | input | 3 | Acknowledge code |
| rsp_rdata | input | 32 | Read data |
| busy | output | 1 | Script in progress |
| done | output | 1 | Core halted, script finished |
| err | output | 1 | Script ended with an error |
| err_cause | output | 3 | 1 fault, 2 wait exhausted, 3 poll timeout, 4 ID mismatch |
| err_step | output | 4 | Step number that failed |
| idcode | output | 32 | Captured ID value |

## Verification
The hardest cases to reach from the ports are the limit boundaries. Examples are the exact 16th versus 17th WAIT on one step, and the 32nd power-up read or the 64th halt read that still shows no acknowledge. All of them depend on what the target answers and not on what the controller drives. The bench therefore contains a behavioural engine with knobs. Each knob injects WAIT, FAULT or an illegal code at a chosen request index, or sets how many power-up reads and halt reads return "not yet". Each limit is then driven both just inside and just past its bound.

// File: rtl/swdh_pkg.sv
package swdh_pkg;

  typedef enum logic [1:0] {
    OP_XFER       = 2'd0,
    OP_LINE_RESET = 2'd1,
    OP_SEQ16      = 2'd2
  } swd_op_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_FAULT  = 3'd1,
    CAUSE_WAIT   = 3'd2,
    CAUSE_POLL   = 3'd3,
    CAUSE_IDCODE = 3'd4
  } err_cause_e;

  typedef struct packed {
    swd_op_e     op;
    logic        ap;
    logic        rnw;
    logic [1:0]  addr;
    logic [31:0] wdata;
  } swd_req_t;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;

  localparam int unsigned STEP_W = 4;
  localparam logic [STEP_W-1:0] STEP_ID       = 4'd3;
  localparam logic [STEP_W-1:0] STEP_PWR_POLL = 4'd5;
  localparam logic [STEP_W-1:0] STEP_TAR      = 4'd11;
  localparam logic [STEP_W-1:0] STEP_DRW_RD   = 4'd13;
  localparam logic [STEP_W-1:0] STEP_HALT_CHK = 4'd14;

  localparam logic [15:0] SWITCH_PATTERN = 16'hE79E;
  localparam logic [31:0] PWRUP_REQ      = 32'h5000_0000;
  localparam logic [31:0] SEL_ID_BANK    = 32'h0000_00F0;
  localparam logic [31:0] CSW_WORD       = 32'h2300_0002;
  localparam logic [31:0] HALT_REG_ADDR  = 32'hE000_EDF0;
  localparam logic [31:0] HALT_REQ_WORD  = 32'hA05F_0003;

endpackage

// File: rtl/swdh_script.sv
module swdh_script
  import swdh_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output swd_req_t          req
);
  function automatic swd_req_t xfer(input logic ap, input logic rnw,
                                    input logic [1:0] addr, input logic [31:0] wd);
    swd_req_t r;
    r.op    = OP_XFER;
    r.ap    = ap;
    r.rnw   = rnw;
    r.addr  = addr;
    r.wdata = wd;
    return r;
  endfunction

  always_comb begin
    case (step)
      4'd0, 4'd2: req = '{op: OP_LINE_RESET, ap: 1'b0, rnw: 1'b0, addr: 2'd0, wdata: 32'd0};
      4'd1:  req = '{op: OP_SEQ16, ap: 1'b0, rnw: 1'b0, addr: 2'd0,
                     wdata: {16'd0, SWITCH_PATTERN}};
      4'd3:  req = xfer(1'b0, 1'b1, 2'd0, 32'd0);
      4'd4:  req = xfer(1'b0, 1'b0, 2'd1, PWRUP_REQ);
      4'd5:  req = xfer(1'b0, 1'b1, 2'd1, 32'd0);
      4'd6:  req = xfer(1'b0, 1'b0, 2'd2, SEL_ID_BANK);
      4'd7:  req = xfer(1'b1, 1'b1, 2'd3, 32'd0);
      4'd8:  req = xfer(1'b0, 1'b1, 2'd3, 32'd0);
      4'd9:  req = xfer(1'b0, 1'b0, 2'd2, 32'd0);
      4'd10: req = xfer(1'b1, 1'b0, 2'd0, CSW_WORD);
      4'd11: req = xfer(1'b1, 1'b0, 2'd1, HALT_REG_ADDR);
      4'd12: req = xfer(1'b1, 1'b0, 2'd3, HALT_REQ_WORD);
      4'd13: req = xfer(1'b1, 1'b1, 2'd3, 32'd0);
      default: req = xfer(1'b0, 1'b1, 2'd3, 32'd0);
    endcase
  end
endmodule

// File: rtl/swdh_cnt.sv
module swdh_cnt #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  // R6 R3 R5
  cnt_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> (cnt != {W{1'b1}}));
endmodule

// File: rtl/swd_halt_seq.sv
module swd_halt_seq
  import swdh_pkg::*;
#(
  parameter int unsigned WAIT_RETRIES = 16,
  parameter int unsigned PWR_POLLS    = 32,
  parameter int unsigned HALT_POLLS   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rehalt,
  input  logic        id_check_en,
  input  logic [31:0] id_expect,
  input  logic [31:0] id_mask,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [1:0]  req_op,
  output logic        req_ap,
  output logic        req_rnw,
  output logic [1:0]  req_addr,
  output logic [31:0] req_wdata,
  input  logic        rsp_valid,
  input  logic [2:0]  rsp_ack,
  input  logic [31:0] rsp_rdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [2:0]  err_cause,
  output logic [3:0]  err_step,
  output logic [31:0] idcode
);
  localparam int unsigned WAIT_CW  = $clog2(WAIT_RETRIES + 1);
  localparam int unsigned POLL_MAX = (PWR_POLLS > HALT_POLLS) ? PWR_POLLS : HALT_POLLS;
  localparam int unsigned POLL_CW  = $clog2(POLL_MAX);
  localparam logic [STEP_W-1:0] STEP_ONE = 1;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RSP, S_DONE, S_ERR} state_e;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  state_e            state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [31:0]       idcode_q;
  err_cause_e        cause_q, cause_d;
  logic [STEP_W-1:0] estep_q;
  logic              id_en, fail, cause_en;
  logic              wait_clr, wait_inc, poll_clr, poll_inc;
  logic [WAIT_CW-1:0] wait_cnt;
  logic [POLL_CW-1:0] poll_cnt;
  swd_req_t          cur_req;
  logic              id_bad, pwr_acked, core_halted;

  swdh_script u_script (.step(step_q), .req(cur_req));

  swdh_cnt #(.W(WAIT_CW)) u_wait_cnt (
    .clk(clk), .rst_n(rst_ni), .clr(wait_clr), .inc(wait_inc), .cnt(wait_cnt));

  swdh_cnt #(.W(POLL_CW)) u_poll_cnt (
    .clk(clk), .rst_n(rst_ni), .clr(poll_clr), .inc(poll_inc), .cnt(poll_cnt));

  always_comb begin
    id_bad      = id_check_en && (((rsp_rdata ^ id_expect) & id_mask) != 32'd0);
    pwr_acked   = rsp_rdata[31] && rsp_rdata[29];
    core_halted = (rsp_rdata[17:16] == 2'b11);
  end

  // Next-state process
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    cause_d  = cause_q;
    id_en    = 1'b0;
    fail     = 1'b0;
    cause_en = 1'b0;
    wait_clr = 1'b0;
    wait_inc = 1'b0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    case (state_q)
      S_IDLE, S_ERR: begin
        if (start) begin
          state_d = S_REQ; step_d = '0; wait_clr = 1'b1; poll_clr = 1'b1;
          cause_d = CAUSE_NONE; cause_en = 1'b1;
        end
      end
      S_DONE: begin
        if (start) begin
          state_d = S_REQ; step_d = '0; wait_clr = 1'b1; poll_clr = 1'b1;
        end else if (rehalt) begin
          state_d = S_REQ; step_d = STEP_TAR; wait_clr = 1'b1; poll_clr = 1'b1;
        end
      end
      S_REQ: if (req_ready) state_d = S_RSP;
      S_RSP: begin
        if (rsp_valid) begin
          state_d = S_REQ;
          if (cur_req.op != OP_XFER) begin
            step_d = step_q + STEP_ONE;
          end else if (rsp_ack == ACK_WAIT) begin
            if (wait_cnt == WAIT_CW'(WAIT_RETRIES)) begin
              fail = 1'b1; cause_d = CAUSE_WAIT;
            end else begin
              wait_inc = 1'b1;
            end
          end else if (rsp_ack != ACK_OK) begin
            fail = 1'b1; cause_d = CAUSE_FAULT;
          end else begin
            wait_clr = 1'b1;
            case (step_q)
              STEP_ID: begin
                id_en = 1'b1;
                if (id_bad) begin fail = 1'b1; cause_d = CAUSE_IDCODE; end
                else step_d = step_q + STEP_ONE;
              end
              STEP_PWR_POLL: begin
                if (pwr_acked) begin
                  poll_clr = 1'b1; step_d = step_q + STEP_ONE;
                end else if (poll_cnt == POLL_CW'(PWR_POLLS - 1)) begin
                  fail = 1'b1; cause_d = CAUSE_POLL;
                end else begin
                  poll_inc = 1'b1;
                end
              end
              STEP_HALT_CHK: begin
                if (core_halted) begin
                  state_d = S_DONE;
                end else if (poll_cnt == POLL_CW'(HALT_POLLS - 1)) begin
                  fail = 1'b1; cause_d = CAUSE_POLL;
                end else begin
                  poll_inc = 1'b1; step_d = STEP_DRW_RD;
                end
              end
              default: step_d = step_q + STEP_ONE;
            endcase
          end
          if (fail) begin
            state_d  = S_ERR;
            cause_en = 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      step_q   <= '0;
      idcode_q <= '0;
      cause_q  <= CAUSE_NONE;
      estep_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (id_en)    idcode_q <= rsp_rdata;
      if (cause_en) cause_q  <= cause_d;
      if (fail)     estep_q  <= step_q;
    end
  end

  assign req_valid = (state_q == S_REQ);
  assign req_op    = cur_req.op;
  assign req_ap    = cur_req.ap;
  assign req_rnw   = cur_req.rnw;
  assign req_addr  = cur_req.addr;
  assign req_wdata = cur_req.wdata;
  assign busy      = (state_q == S_REQ) || (state_q == S_RSP);
  assign done      = (state_q == S_DONE);
  assign err       = (state_q == S_ERR);
  assign err_cause = cause_q;
  assign err_step  = estep_q;
  assign idcode    = idcode_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_op) && $stable(req_ap) &&
      $stable(req_rnw) && $stable(req_addr) && $stable(req_wdata)));

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(done) |-> $past(rsp_valid && rsp_ack == ACK_OK && rsp_rdata[17:16] == 2'b11));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(err) |-> ($past(rsp_valid) && err_cause != 3'd0));

  // R9
  rehalt_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(done) && $past(rehalt) && !$past(start) && req_valid) |-> (req_op == 2'd0));
endmodule

// File: tb/swd_halt_seq_tb.sv
module swd_halt_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, start, rehalt, id_check_en;
  logic [31:0] id_expect, id_mask;
  logic req_valid, req_ready, req_ap, req_rnw;
  logic [1:0] req_op, req_addr;
  logic [31:0] req_wdata;
  logic rsp_valid;
  logic [2:0] rsp_ack;
  logic [31:0] rsp_rdata;
  logic busy, done, err;
  logic [2:0] err_cause;
  logic [3:0] err_step;
  logic [31:0] idcode;

  always #(CLK_PERIOD/2) clk = ~clk;

  swd_halt_seq dut_i (.*);

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Engine model state and knobs
  logic [1:0]  lg_op [256];
  logic        lg_ap [256], lg_rnw [256];
  logic [1:0]  lg_addr [256];
  logic [31:0] lg_wd [256];
  int log_n;
  int fault_at, bad_at, wait_at, wait_n, wait_left;
  int pwr_lat, pwr_reads, halt_lat, halt_reads;
  logic [31:0] idcode_val, sel_reg, pend;

  initial begin
    req_ready = 0; rsp_valid = 0; rsp_ack = 0; rsp_rdata = 0;
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        automatic logic [1:0] c_op = req_op;
        automatic logic c_ap = req_ap, c_rnw = req_rnw;
        automatic logic [1:0] c_addr = req_addr;
        automatic logic [31:0] c_wd = req_wdata;
        automatic logic [2:0] ack = 3'b001;
        automatic logic [31:0] rd = 32'd0;
        automatic int idx = log_n;
        @(negedge clk);
        // R10: request held while not yet accepted
        check(req_valid && req_op == c_op && req_ap == c_ap && req_rnw == c_rnw &&
              req_addr == c_addr && req_wdata == c_wd, "R10 hold", {30'd0, req_op, req_wdata}, {30'd0, c_op, c_wd});
        req_ready = 1;
        if (idx < 256) begin
          lg_op[idx] = c_op; lg_ap[idx] = c_ap; lg_rnw[idx] = c_rnw;
          lg_addr[idx] = c_addr; lg_wd[idx] = c_wd;
        end
        log_n++;
        if (idx == wait_at) wait_left = wait_n;
        if (idx == fault_at) ack = 3'b100;
        else if (idx == bad_at) ack = 3'b111;
        else if (wait_left > 0) begin ack = 3'b010; wait_left--; end
        if (ack == 3'b001 && c_op == 2'd0) begin
          if (!c_ap && c_rnw && c_addr == 2'd0) rd = idcode_val;
          else if (!c_ap && c_rnw && c_addr == 2'd1) begin
            pwr_reads++;
            rd = (pwr_reads > pwr_lat) ? 32'hF000_0000 : 32'h5000_0000;
          end else if (!c_ap && !c_rnw && c_addr == 2'd2) sel_reg = c_wd;
          else if (c_ap && c_rnw && c_addr == 2'd3) begin
            if (sel_reg == 32'hF0) pend = 32'h0477_0031;
            else begin
              halt_reads++;
              pend = (halt_reads > halt_lat) ? 32'h0003_0003 : 32'h0000_0003;
            end
          end else if (!c_ap && c_rnw && c_addr == 2'd3) rd = pend;
        end
        @(negedge clk);
        req_ready = 0;
        rsp_valid = 1; rsp_ack = ack; rsp_rdata = rd;
        @(negedge clk);
        rsp_valid = 0;
      end
    end
  end

  task automatic clear_knobs();
    log_n = 0; fault_at = -1; bad_at = -1; wait_at = -1; wait_n = 0; wait_left = 0;
    pwr_lat = 0; pwr_reads = 0; halt_lat = 0; halt_reads = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0; rehalt = 0;
    clear_knobs(); sel_reg = 0; pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input bit is_start);
    @(negedge clk);
    if (is_start) start = 1; else rehalt = 1;
    @(negedge clk);
    start = 0; rehalt = 0;
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (!(done || err) && n < 20000) begin @(negedge clk); n++; end
    check(done || err, {tag, " run ended"}, 64'(n), 64'd20000);
  endtask

  function automatic int count_reads(input logic ap, input logic [1:0] addr);
    int c = 0;
    for (int i = 0; i < log_n && i < 256; i++)
      if (lg_op[i] == 2'd0 && lg_ap[i] == ap && lg_rnw[i] && lg_addr[i] == addr) c++;
    return c;
  endfunction

  // {op, ap, rnw, addr, wdata}
  localparam logic [37:0] EXP_SEQ [15] = '{
    {2'd1, 1'b0, 1'b0, 2'd0, 32'h0},
    {2'd2, 1'b0, 1'b0, 2'd0, 32'h0000_E79E},
    {2'd1, 1'b0, 1'b0, 2'd0, 32'h0},
    {2'd0, 1'b0, 1'b1, 2'd0, 32'h0},
    {2'd0, 1'b0, 1'b0, 2'd1, 32'h5000_0000},
    {2'd0, 1'b0, 1'b1, 2'd1, 32'h0},
    {2'd0, 1'b0, 1'b0, 2'd2, 32'h0000_00F0},
    {2'd0, 1'b1, 1'b1, 2'd3, 32'h0},
    {2'd0, 1'b0, 1'b1, 2'd3, 32'h0},
    {2'd0, 1'b0, 1'b0, 2'd2, 32'h0},
    {2'd0, 1'b1, 1'b0, 2'd0, 32'h2300_0002},
    {2'd0, 1'b1, 1'b0, 2'd1, 32'hE000_EDF0},
    {2'd0, 1'b1, 1'b0, 2'd3, 32'hA05F_0003},
    {2'd0, 1'b1, 1'b1, 2'd3, 32'h0},
    {2'd0, 1'b0, 1'b1, 2'd3, 32'h0}
  };

  initial begin
    int ok_seen;
    id_check_en = 0; id_expect = 0; id_mask = 0; idcode_val = 32'h0BB1_1477;
    do_reset();

    // R1 reset state
    check(!done && !err && !busy && !req_valid && idcode == 0 && err_cause == 0,
          "R1 reset state", {31'd0, done, err, busy, req_valid, idcode}, 64'd0);

    // R9 rehalt ignored while idle
    pulse(0);
    ok_seen = 1;
    repeat (6) begin @(negedge clk); if (req_valid || busy) ok_seen = 0; end
    check(ok_seen == 1, "R9 rehalt ignored when not done", 64'(req_valid), 64'd0);

    // R2 R4 R5: full script, table walk; R11: start while busy ignored
    pulse(1);
    repeat (20) @(negedge clk);
    pulse(1);
    wait_end("R2");
    check(done && log_n == 15, "R11 start while busy ignored / R5 done", 64'(log_n), 64'd15);
    for (int i = 0; i < 15; i++) begin
      automatic logic [37:0] e = EXP_SEQ[i];
      automatic bit ok = lg_op[i] == e[37:36] && lg_ap[i] == e[35] && lg_rnw[i] == e[34] &&
                         lg_addr[i] == e[33:32];
      if (e[37:36] == 2'd2) ok = ok && lg_wd[i][15:0] == e[15:0];
      else if (e[37:36] == 2'd0 && !e[34]) ok = ok && lg_wd[i] == e[31:0];
      check(ok, $sformatf("R2/R4/R5 step %0d", i),
            {26'd0, lg_op[i], lg_ap[i], lg_rnw[i], lg_addr[i], lg_wd[i]}, {26'd0, e});
    end
    check(idcode == 32'h0BB1_1477, "R2 idcode captured", idcode, 32'h0BB1_1477);

    // R9 rehalt from done, with two not-halted polls (R5)
    log_n = 0; halt_reads = 0; halt_lat = 2;
    pulse(0);
    wait_end("R9");
    check(done && log_n == 8, "R9/R5 rehalt request count", 64'(log_n), 64'd8);
    check(lg_op[0] == 0 && lg_ap[0] && !lg_rnw[0] && lg_addr[0] == 1 && lg_wd[0] == 32'hE000_EDF0,
          "R9 rehalt starts at address write", lg_wd[0], 32'hE000_EDF0);
    check(lg_wd[1] == 32'hA05F_0003 && lg_addr[1] == 3, "R5 halt word", lg_wd[1], 32'hA05F_0003);

    // R3 power-up acknowledged after 3 misses
    do_reset(); pwr_lat = 3;
    pulse(1); wait_end("R3");
    check(done && count_reads(1'b0, 2'd1) == 4, "R3 power poll count", 64'(count_reads(1'b0, 2'd1)), 64'd4);

    // R3 power-up never acknowledged
    do_reset(); pwr_lat = 1000;
    pulse(1); wait_end("R3b");
    check(err && err_cause == 3 && err_step == 5, "R3 power timeout code", {err_cause, err_step}, {3'd3, 4'd5});
    check(count_reads(1'b0, 2'd1) == 32, "R3 power poll limit", 64'(count_reads(1'b0, 2'd1)), 64'd32);

    // R11 start from error reruns full script
    clear_knobs();
    pulse(1); wait_end("R11");
    check(done && log_n == 15 && lg_op[0] == 2'd1, "R11 restart from error", 64'(log_n), 64'd15);

    // R5 halt never confirmed
    do_reset(); halt_lat = 1000;
    pulse(1); wait_end("R5");
    check(err && err_cause == 3 && err_step == 14, "R5 halt timeout code", {err_cause, err_step}, {3'd3, 4'd14});
    check(halt_reads == 64, "R5 halt poll limit", 64'(halt_reads), 64'd64);

    // R6 16 WAITs on ID read are absorbed
    do_reset(); wait_at = 3; wait_n = 16;
    pulse(1); wait_end("R6");
    check(done && log_n == 31, "R6 16 retries then done", 64'(log_n), 64'd31);

    // R6 17 WAITs exhaust retries
    do_reset(); wait_at = 3; wait_n = 17;
    pulse(1); wait_end("R6b");
    check(err && err_cause == 2 && err_step == 3, "R6 wait exhausted code", {err_cause, err_step}, {3'd2, 4'd3});
    check(log_n == 20, "R6 attempts on failing step", 64'(log_n), 64'd20);

    // R7 FAULT on power-up write
    do_reset(); fault_at = 4;
    pulse(1); wait_end("R7");
    check(err && err_cause == 1 && err_step == 4, "R7 fault code", {err_cause, err_step}, {3'd1, 4'd4});

    // R7 illegal ack on CSW write
    do_reset(); bad_at = 10;
    pulse(1); wait_end("R7b");
    check(err && err_cause == 1 && err_step == 10, "R7 illegal ack code", {err_cause, err_step}, {3'd1, 4'd10});

    // R7 ack ignored for line reset
    do_reset(); fault_at = 0;
    pulse(1); wait_end("R7c");
    check(done, "R7 line reset ack ignored", 64'(err_cause), 64'd0);

    // R8 ID mismatch inside mask
    do_reset(); idcode_val = 32'h0BC1_1477; id_check_en = 1;
    id_expect = 32'h0BB1_1477; id_mask = 32'hFFFF_FFFF;
    pulse(1); wait_end("R8");
    check(err && err_cause == 4 && err_step == 3, "R8 mismatch code", {err_cause, err_step}, {3'd4, 4'd3});
    check(idcode == 32'h0BC1_1477, "R8 idcode captured on mismatch", idcode, 32'h0BC1_1477);

    // R8 difference outside mask ignored
    do_reset(); id_mask = 32'h0F0F_FFFF;
    pulse(1); wait_end("R8b");
    check(done && log_n == 15, "R8 masked difference ignored", 64'(err_cause), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule